// File: doc/BRIEF.md
# Masked Event Interrupt with Acknowledge Readout

This block gathers three device events into a pending register: a packet-ready event, an autopoll marker that travels with packets produced by polling, and a once-per-period tick. It raises an active-low interrupt whenever a pending event is also enabled in a programmable mask. Software services the interrupt with an acknowledge command. The block answers with a byte stream that reports the pending events and then clears them.

The acknowledge is selective. If a packet is waiting, the response carries only the packet flags and the stored packet bytes. Only those flags are cleared, so a tick that is pending at the same time stays pending for a later acknowledge. If no packet is waiting, one byte reports every pending event and all of them are cleared.

A built-in autopoll timer asks the packet source for data at a fixed period while a nonzero poll mask is configured. It does not ask while a packet is already pending. The packet source and any seconds counter lie outside the block. A packet is handed in as a length and a byte vector.

Top module: `evt_irq_ack`

## Requirements
- R1: `irq_n_o` is low exactly when (pending AND mask) is nonzero and high otherwise. It follows a change of pending or mask in the cycle after the clock edge that makes the change. Pending bit 2 is the autopoll flag, bit 3 the tick and bit 4 the packet event.
- R2: After reset the mask is 0x18 (packet and tick enabled), pending is 0x00, autopoll is off (`poll_mask_o` = 0) and no response is streaming.
- R3: A command with code 0x4B and an argument count of exactly 1 replaces the mask with argument byte 0 (`cmd_args_i[7:0]`). With any other argument count the mask is unchanged.
- R4: An acknowledge (code 0x4A, argument count 0) while bit 4 is pending streams, one byte per cycle from the cycle after the command, first (pending AND 0x14) and then the stored packet bytes in arrival order. It clears only bits 4 and 2 and empties the packet store. Bit 3 stays pending. `rsp_last_o` marks the final byte.
- R5: An acknowledge while bit 4 is clear streams a single byte equal to the pending register and clears all pending bits. An acknowledge with a nonzero argument count produces no response and changes nothing.
- R6: Bit 3 is set once every TICK_CYCLES cycles on a fixed schedule counted from reset, independent of when acknowledges occur.
- R7: While the poll mask is nonzero, `poll_req_o` pulses every POLL_CYCLES cycles, except that a pulse is withheld while bit 4 is pending. An accepted packet with `pkt_auto_i`=1 sets bits 4 and 2. With `pkt_auto_i`=0 it sets bit 4 only. A packet whose length is 0 or above MAX_PKT is ignored. Packet byte k is `pkt_data_i[8k+7:8k]`.
- R8: A command with code 0x20, argument count 4 and argument bytes 0x00, 0x86, hi, lo sets the poll mask to {hi, lo}. Argument byte k is `cmd_args_i[8k+7:8k]`. A changed nonzero mask restarts the poll period, a zero mask stops polling, and a mask equal to the current one has no effect. Any other code-0x20 form leaves polling untouched.
- R9: Every command arriving while a response is streaming is ignored.
- R10: A packet that arrives while bit 4 is pending is dropped. An event set in the same cycle as an acknowledge survives that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_code_i | input | 8 | Command code |
| cmd_argc_i | input | 3 | Number of argument bytes |
| cmd_args_i | input | 32 | Argument bytes, byte k at bits 8k+7:8k |
| pkt_valid_i | input | 1 | Packet hand-over strobe |
| pkt_auto_i | input | 1 | Packet came from an autopoll |
| pkt_len_i | input | $clog2(MAX_PKT+1) | Packet length in bytes |
| pkt_data_i | input | 8*MAX_PKT | Packet bytes, byte k at bits 8k+7:8k |
| irq_n_o | output | 1 | Active-low interrupt |
| rsp_valid_o | output | 1 | Response byte valid |
| rsp_data_o | output | 8 | Response byte |
| rsp_last_o | output | 1 | Final response byte |
| poll_req_o | output | 1 | Request to poll the packet source |
| poll_mask_o | output | 16 | Current poll mask |

## Verification
A corrupted pending or mask register shows on `irq_n_o` one cycle after the edge that corrupts it. It also shows in the first byte of the next acknowledge. A wrong packet store or response counter shows as wrong, missing or extra bytes in the cycles right after an acknowledge. A tick or poll counter that drifts shows as a tick or `poll_req_o` arriving in the wrong cycle, at most one period later. The reference model predicts every output on every cycle, so each such fault is reported in the cycle it first appears.

// File: rtl/evt_pkg.sv
// Shared constants for the masked event interrupt block.
// Assumes 8-bit pending/mask registers and a 16-bit poll mask.
package evt_pkg;
    localparam int BIT_AUTO = 2;
    localparam int BIT_TICK = 3;
    localparam int BIT_PKT  = 4;

    localparam logic [7:0] FLAG_AUTO  = 8'(1 << BIT_AUTO);
    localparam logic [7:0] FLAG_TICK  = 8'(1 << BIT_TICK);
    localparam logic [7:0] FLAG_PKT   = 8'(1 << BIT_PKT);
    localparam logic [7:0] PKT_FLAGS  = FLAG_PKT | FLAG_AUTO;
    localparam logic [7:0] MASK_RESET = FLAG_PKT | FLAG_TICK;

    localparam logic [7:0] CMD_ACK  = 8'h4A;
    localparam logic [7:0] CMD_MASK = 8'h4B;
    localparam logic [7:0] CMD_PKT  = 8'h20;
    localparam logic [7:0] AP_SIG0  = 8'h00;
    localparam logic [7:0] AP_SIG1  = 8'h86;

    typedef struct packed {
        logic mask_wr;
        logic ack;
        logic ap_cfg;
    } cmd_dec_t;
endpackage

// File: rtl/evt_timers.sv
// Tick and autopoll timers.
// The tick counter runs freely from reset, so its schedule never depends on
// servicing. The poll counter runs only while the poll mask is nonzero and
// restarts when a changed mask is written. Assumes TICK_CYCLES>1, POLL_CYCLES>1.
module evt_timers #(
    parameter int TICK_CYCLES = 1000,
    parameter int POLL_CYCLES = 30,
    parameter int MASK_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid_i,
    input  logic [MASK_W-1:0] cfg_mask_i,
    input  logic              pkt_pending_i,
    output logic              tick_o,
    output logic              poll_req_o,
    output logic [MASK_W-1:0] ap_mask_o
);
    localparam int TW = $clog2(TICK_CYCLES + 1);
    localparam int PW = $clog2(POLL_CYCLES + 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CYCLES - 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(POLL_CYCLES - 1);

    logic [TW-1:0]     tick_cnt_q;
    logic [PW-1:0]     poll_cnt_q;
    logic [MASK_W-1:0] ap_mask_q;
    logic              cfg_change;
    logic              poll_wrap;

    assign tick_o     = (tick_cnt_q == TICK_LAST);
    assign cfg_change = cfg_valid_i && (cfg_mask_i != ap_mask_q);
    assign poll_wrap  = (poll_cnt_q == POLL_LAST);
    assign poll_req_o = (ap_mask_q != '0) && poll_wrap && !pkt_pending_i;
    assign ap_mask_o  = ap_mask_q;

    // Free-running tick period counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      tick_cnt_q <= '0;
        else if (tick_o) tick_cnt_q <= '0;
        else             tick_cnt_q <= tick_cnt_q + 1'b1;
    end

    // Poll mask register, written only on a change.
    always_ff @(posedge clk) begin
        if (!rst_n)          ap_mask_q <= '0;
        else if (cfg_change) ap_mask_q <= cfg_mask_i;
    end

    // Poll period counter, restarted by a changed mask.
    always_ff @(posedge clk) begin
        if (!rst_n)                 poll_cnt_q <= '0;
        else if (cfg_change)        poll_cnt_q <= '0;
        else if (ap_mask_q != '0)   poll_cnt_q <= poll_wrap ? '0 : poll_cnt_q + 1'b1;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R6

    AST_POLL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_change && cfg_mask_i != '0) |=> !poll_req_o); // R8
endmodule

// File: rtl/evt_rsp.sv
// Response byte streamer.
// A load captures a snapshot of up to MAX_BYTES bytes and a count. The bytes
// then leave one per cycle, lowest byte first. Assumes no load while busy.
module evt_rsp #(
    parameter int MAX_BYTES = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic [CW-1:0]          load_cnt_i,
    input  logic [MAX_BYTES*8-1:0] load_data_i,
    output logic                   busy_o,
    output logic                   rsp_valid_o,
    output logic [7:0]             rsp_data_o,
    output logic                   rsp_last_o
);
    localparam int CW = $clog2(MAX_BYTES + 1);

    logic [MAX_BYTES*8-1:0] buf_q;
    logic [CW-1:0]          left_q;

    assign busy_o      = (left_q != '0);
    assign rsp_valid_o = busy_o;
    assign rsp_data_o  = buf_q[7:0];
    assign rsp_last_o  = (left_q == CW'(1));

    // Snapshot on load, then shift one byte out per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            left_q <= '0;
        end else if (load_i) begin
            buf_q  <= load_data_i;
            left_q <= load_cnt_i;
        end else if (busy_o) begin
            buf_q  <= buf_q >> 8;
            left_q <= left_q - 1'b1;
        end
    end

    AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !busy_o); // R9

    AST_RSP_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_last_o) |=> rsp_valid_o); // R4
endmodule

// File: rtl/evt_irq_ack.sv
// Masked event interrupt with selective acknowledge readout.
// Holds pending events, the mask and one packet. It decodes the mask,
// acknowledge and autopoll commands, and drives the active-low interrupt
// from registered state. Assumes one command per strobe and at most
// MAX_PKT bytes per packet.
module evt_irq_ack #(
    parameter int TICK_CYCLES = 1000,
    parameter int POLL_CYCLES = 30,
    parameter int MAX_PKT     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid_i,
    input  logic [7:0]                cmd_code_i,
    input  logic [2:0]                cmd_argc_i,
    input  logic [31:0]               cmd_args_i,
    input  logic                      pkt_valid_i,
    input  logic                      pkt_auto_i,
    input  logic [$clog2(MAX_PKT+1)-1:0] pkt_len_i,
    input  logic [MAX_PKT*8-1:0]      pkt_data_i,
    output logic                      irq_n_o,
    output logic                      rsp_valid_o,
    output logic [7:0]                rsp_data_o,
    output logic                      rsp_last_o,
    output logic                      poll_req_o,
    output logic [15:0]               poll_mask_o
);
    import evt_pkg::*;

    localparam int LW = $clog2(MAX_PKT + 1);
    localparam int RB = MAX_PKT + 1;
    localparam int RW = $clog2(RB + 1);

    logic [7:0]           pending_q, mask_q, clr, set;
    logic [LW-1:0]        pkt_len_q;
    logic [MAX_PKT*8-1:0] pkt_buf_q, pkt_buf_d;
    logic                 busy, accept, pkt_take, tick;
    cmd_dec_t             dec;
    logic [RB*8-1:0]      rsp_bytes;
    logic [RW-1:0]        rsp_cnt;

    // Decode commands; all of them are blocked while a response streams.
    always_comb begin
        accept      = cmd_valid_i && !busy;
        dec.mask_wr = accept && (cmd_code_i == CMD_MASK) && (cmd_argc_i == 3'd1);
        dec.ack     = accept && (cmd_code_i == CMD_ACK)  && (cmd_argc_i == 3'd0);
        dec.ap_cfg  = accept && (cmd_code_i == CMD_PKT)  && (cmd_argc_i == 3'd4)
                      && (cmd_args_i[7:0] == AP_SIG0) && (cmd_args_i[15:8] == AP_SIG1);
    end

    // A packet is taken only when none is pending and its length fits.
    assign pkt_take = pkt_valid_i && (pkt_len_i != '0) && (pkt_len_i <= LW'(MAX_PKT))
                      && !pending_q[BIT_PKT];

    // Byte lanes of the packet store; lanes past the length are zeroed.
    for (genvar i = 0; i < MAX_PKT; i++) begin : g_lane
        assign pkt_buf_d[i*8 +: 8] = (LW'(i) < pkt_len_i) ? pkt_data_i[i*8 +: 8] : 8'h00;
    end

    // Response snapshot and the pending bits to clear at acknowledge.
    always_comb begin
        if (pending_q[BIT_PKT]) begin
            rsp_bytes = {pkt_buf_q, pending_q & PKT_FLAGS};
            rsp_cnt   = RW'(pkt_len_q) + RW'(1);
        end else begin
            rsp_bytes = {{(MAX_PKT*8){1'b0}}, pending_q};
            rsp_cnt   = RW'(1);
        end
        clr = '0;
        if (dec.ack) clr = pending_q[BIT_PKT] ? PKT_FLAGS : 8'hFF;
        set = '0;
        if (tick)     set = set | FLAG_TICK;
        if (pkt_take) set = set | (pkt_auto_i ? PKT_FLAGS : FLAG_PKT);
    end

    // Pending register: new events win over the clear of the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pending_q <= '0;
        else        pending_q <= (pending_q & ~clr) | set;
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)           mask_q <= MASK_RESET;
        else if (dec.mask_wr) mask_q <= cmd_args_i[7:0];
    end

    // Packet store: filled on take, emptied by a packet acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_len_q <= '0;
            pkt_buf_q <= '0;
        end else if (pkt_take) begin
            pkt_len_q <= pkt_len_i;
            pkt_buf_q <= pkt_buf_d;
        end else if (dec.ack && pending_q[BIT_PKT]) begin
            pkt_len_q <= '0;
        end
    end

    assign irq_n_o = ~|(pending_q & mask_q);

    evt_timers #(
        .TICK_CYCLES(TICK_CYCLES),
        .POLL_CYCLES(POLL_CYCLES),
        .MASK_W     (16)
    ) u_timers (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_valid_i  (dec.ap_cfg),
        .cfg_mask_i   ({cmd_args_i[23:16], cmd_args_i[31:24]}),
        .pkt_pending_i(pending_q[BIT_PKT]),
        .tick_o       (tick),
        .poll_req_o   (poll_req_o),
        .ap_mask_o    (poll_mask_o)
    );

    evt_rsp #(
        .MAX_BYTES(RB)
    ) u_rsp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (dec.ack),
        .load_cnt_i (rsp_cnt),
        .load_data_i(rsp_bytes),
        .busy_o     (busy),
        .rsp_valid_o(rsp_valid_o),
        .rsp_data_o (rsp_data_o),
        .rsp_last_o (rsp_last_o)
    );

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dec.mask_wr |=> (mask_q == $past(cmd_args_i[7:0]))); // R3

    AST_MASK_BAD_ARGC: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_code_i == CMD_MASK && cmd_argc_i != 3'd1) |=> $stable(mask_q)); // R3

    AST_PKT_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.ack && pending_q[BIT_PKT]) |=>
            (!pending_q[BIT_PKT] && !pending_q[BIT_AUTO] && pkt_len_q == '0)); // R4

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.ack && !pending_q[BIT_PKT]) |=> (rsp_valid_o && rsp_last_o)); // R5

    AST_NO_POLL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req_o |-> !pending_q[BIT_PKT]); // R7
endmodule

// File: tb/evt_irq_ack_test.sv
module evt_irq_ack_test;
    localparam int TICK = 5000;
    localparam int POLL = 30;
    localparam int MAXP = 4;
    localparam int LW   = $clog2(MAXP + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [7:0]      cmd_code = '0;
    logic [2:0]      cmd_argc = '0;
    logic [31:0]     cmd_args = '0;
    logic            pkt_valid = 1'b0;
    logic            pkt_auto = 1'b0;
    logic [LW-1:0]   pkt_len = '0;
    logic [MAXP*8-1:0] pkt_data = '0;
    logic            irq_n, rsp_valid, rsp_last, poll_req;
    logic [7:0]      rsp_data;
    logic [15:0]     poll_mask;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;
    logic [7:0] got[$];

    always #5 clk = ~clk;

    evt_irq_ack #(.TICK_CYCLES(TICK), .POLL_CYCLES(POLL), .MAX_PKT(MAXP)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code), .cmd_argc_i(cmd_argc),
        .cmd_args_i(cmd_args),
        .pkt_valid_i(pkt_valid), .pkt_auto_i(pkt_auto), .pkt_len_i(pkt_len),
        .pkt_data_i(pkt_data),
        .irq_n_o(irq_n), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
        .rsp_last_o(rsp_last), .poll_req_o(poll_req), .poll_mask_o(poll_mask)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference model, advanced on every clock edge.
    logic [7:0]  m_pend, m_mask, m_clr, m_set;
    logic [15:0] m_ap, m_newap;
    int          m_tc, m_pc;
    bit          m_live = 0, m_busy, m_tk, m_acc;
    logic [7:0]  m_pkt[$];
    logic [7:0]  m_rsp[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 8'h00; m_mask = 8'h18; m_ap = 16'h0;
            m_tc = 0; m_pc = 0; m_pkt.delete(); m_rsp.delete(); m_live = 1;
        end else begin
            m_busy = (m_rsp.size() != 0);
            if (m_busy) void'(m_rsp.pop_front());
            m_tk = (m_tc == TICK - 1);
            m_tc = m_tk ? 0 : m_tc + 1;
            m_clr = 8'h00; m_set = 8'h00;
            m_acc = cmd_valid && !m_busy;
            m_newap = {cmd_args[23:16], cmd_args[31:24]};
            if (m_acc && cmd_code == 8'h20 && cmd_argc == 3'd4 && cmd_args[7:0] == 8'h00
                && cmd_args[15:8] == 8'h86 && m_newap != m_ap) begin
                m_ap = m_newap; m_pc = 0;
            end else if (m_ap != 0) begin
                m_pc = (m_pc == POLL - 1) ? 0 : m_pc + 1;
            end
            if (m_acc && cmd_code == 8'h4B && cmd_argc == 3'd1) m_mask = cmd_args[7:0];
            if (m_acc && cmd_code == 8'h4A && cmd_argc == 3'd0) begin
                if (m_pend[4]) begin
                    m_rsp.push_back(m_pend & 8'h14);
                    foreach (m_pkt[i]) m_rsp.push_back(m_pkt[i]);
                    m_pkt.delete();
                    m_clr = 8'h14;
                end else begin
                    m_rsp.push_back(m_pend);
                    m_clr = 8'hFF;
                end
            end
            if (pkt_valid && pkt_len != 0 && pkt_len <= MAXP && !m_pend[4]) begin
                m_set = m_set | (pkt_auto ? 8'h14 : 8'h10);
                m_pkt.delete();
                for (int i = 0; i < int'(pkt_len); i++) m_pkt.push_back(pkt_data[i*8 +: 8]);
            end
            if (m_tk) m_set = m_set | 8'h08;
            m_pend = (m_pend & ~m_clr) | m_set;
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (m_live && rst_n) begin
            chk("R1 irq_n", irq_n, ((m_pend & m_mask) == 0));
            chk("R4 rsp_valid", rsp_valid, (m_rsp.size() != 0));
            if (m_rsp.size() != 0) begin
                chk("R4 rsp_data", rsp_data, m_rsp[0]);
                chk("R4 rsp_last", rsp_last, (m_rsp.size() == 1));
            end
            chk("R7 poll_req", poll_req, (m_ap != 0 && m_pc == POLL - 1 && !m_pend[4]));
            chk("R8 poll_mask", poll_mask, m_ap);
            if (rsp_valid) got.push_back(rsp_data);
        end
    end

    task automatic cmd(input logic [7:0] code, input logic [2:0] argc, input logic [31:0] args);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; cmd_argc = argc; cmd_args = args;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_pkt(input logic au, input int len, input logic [31:0] data);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_auto = au; pkt_len = LW'(len); pkt_data = data;
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    task automatic ack_check(input string tag, input int n, input logic [39:0] exp);
        got.delete();
        cmd(8'h4A, 3'd0, 32'h0);
        repeat (n + 1) @(negedge clk);
        #1;
        chk({tag, " length"}, got.size(), n);
        for (int i = 0; i < n && i < got.size(); i++)
            chk({tag, " byte"}, got[i], exp[i*8 +: 8]);
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    initial begin
        int t1, t2, cnt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R2 irq_n after reset", irq_n, 1);
        chk("R2 no response after reset", rsp_valid, 0);
        chk("R2 poll mask after reset", poll_mask, 0);

        send_pkt(1'b0, 3, 32'h0033_2211);
        settle();
        chk("R2 reset mask enables packet", irq_n, 0);
        cmd(8'h4B, 3'd2, 32'h0);
        settle();
        chk("R3 bad argc keeps mask", irq_n, 0);
        cmd(8'h4B, 3'd1, 32'h0);
        #1;
        chk("R1 mask write next cycle", irq_n, 1);
        cmd(8'h4B, 3'd1, 32'h18);
        #1;
        chk("R3 mask restored", irq_n, 0);

        got.delete();
        cmd(8'h4A, 3'd1, 32'h0);
        repeat (3) @(negedge clk);
        #1;
        chk("R5 ack with args no response", got.size(), 0);
        chk("R5 ack with args keeps pending", irq_n, 0);

        ack_check("R4 packet ack", 4, 40'h33_2211_10);
        chk("R4 irq after packet ack", irq_n, 1);
        ack_check("R5 empty ack", 1, 40'h00);

        cmd(8'h20, 3'd4, 32'h0100_8600);
        cnt = 0;
        for (int i = 0; i < 2 * POLL; i++) begin
            settle();
            if (poll_req) begin cnt = 1; break; end
        end
        chk("R7 poll request after config", cnt, 1);
        send_pkt(1'b1, 2, 32'h0000_BBAA);
        settle();
        chk("R7 autopoll packet raises irq", irq_n, 0);
        cnt = 0;
        for (int i = 0; i < 3 * POLL; i++) begin
            settle();
            if (poll_req) cnt++;
        end
        chk("R7 no poll while packet pending", cnt, 0);
        ack_check("R7 autopoll ack", 3, 40'hBB_AA14);

        cnt = 0;
        for (int i = 0; i < 2 * POLL; i++) begin
            settle();
            if (poll_req) break;
        end
        repeat (10) @(negedge clk);
        cmd(8'h20, 3'd4, 32'h0100_8600);
        cnt = 0;
        for (int i = 0; i < 2 * POLL; i++) begin
            settle();
            cnt++;
            if (poll_req) break;
        end
        chk("R8 unchanged mask keeps period", (cnt < POLL - 5), 1);
        cmd(8'h20, 3'd3, 32'h0000_8600);
        settle();
        chk("R8 short config ignored", poll_mask, 16'h0001);
        cmd(8'h20, 3'd4, 32'h0000_8600);
        settle();
        chk("R8 zero mask stored", poll_mask, 16'h0000);
        cnt = 0;
        for (int i = 0; i < 3 * POLL; i++) begin
            settle();
            if (poll_req) cnt++;
        end
        chk("R8 zero mask stops polling", cnt, 0);

        send_pkt(1'b0, 1, 32'h44);
        send_pkt(1'b0, 2, 32'h6655);
        ack_check("R10 second packet dropped", 2, 40'h44_10);

        got.delete();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 8'h4A; cmd_argc = 3'd0; cmd_args = '0;
        pkt_valid = 1'b1; pkt_auto = 1'b0; pkt_len = LW'(1); pkt_data = 32'h99;
        @(negedge clk);
        cmd_valid = 1'b0; pkt_valid = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R10 same-cycle ack response", got.size(), 1);
        chk("R10 packet survives ack", irq_n, 0);
        ack_check("R10 surviving packet", 2, 40'h99_10);

        for (int i = 0; i < 2 * TICK; i++) begin
            settle();
            if (!irq_n) break;
        end
        t1 = cyc;
        ack_check("R6 tick ack", 1, 40'h08);
        for (int i = 0; i < 2 * TICK; i++) begin
            settle();
            if (!irq_n) break;
        end
        t2 = cyc;
        chk("R6 fixed tick period", t2 - t1, TICK);

        send_pkt(1'b0, 2, 32'hC35A);
        got.delete();
        cmd(8'h4A, 3'd0, 32'h0);
        cmd(8'h4B, 3'd1, 32'h0);
        repeat (3) @(negedge clk);
        #1;
        chk("R4 selective ack length", got.size(), 3);
        if (got.size() == 3) begin
            chk("R4 selective flags", got[0], 8'h10);
            chk("R4 selective byte", got[1], 8'h5A);
            chk("R4 selective byte", got[2], 8'hC3);
        end
        chk("R9 mask write during stream ignored", irq_n, 0);
        ack_check("R5 tick left pending", 1, 40'h08);
        chk("R5 irq released", irq_n, 1);

        repeat (5) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule